// File: doc/BRIEF.md
# Chip-Selected Register Slave for a Two-Wire Management Bus

This block is the configuration port of a four-lane line-conditioning device. It watches a two-wire management bus (a clock line and an open-drain data line) by oversampling both with the fast system clock. It recognises START and STOP framing and answers one fixed 7-bit address, 0x56, which appears on the wire as 0xAC for a write. A host can write one byte to a register, or read one byte back by writing the register index and then issuing a repeated START with the read bit set.

Nine byte-wide registers sit at indices 0x00 to 0x08. Indices 0x00 to 0x02 are read-only status, and index 0x01 reports the per-lane signal-detect inputs. Indices 0x03 to 0x08 are writable control bytes, which leave the block on a flat vector for the analog lanes. A chip-select input decides whether the block takes part in bus traffic at all. A parameterised clock-low watchdog drops a stalled transfer.

Top module: `smbRegSlave`

## Requirements
- R1: While `chipSel` is low the block never pulls the data line low. It acknowledges nothing and changes no register, whatever traffic is on the bus.
- R2: The block acknowledges (holds data low for the ninth clock) only an address byte whose upper seven bits equal 0x56. Any other address is not acknowledged, and the rest of that transfer is ignored.
- R3: A write (START, 0xAC, index, data, STOP) gets an acknowledge after each of its three bytes. The data byte then lands in the indexed writable register.
- R4: A read (START, 0xAC, index, repeated START, 0xAD, eight data clocks, host NACK, STOP) returns the indexed register most significant bit first, after acknowledging all three host bytes.
- R5: After reset, indices 0x03 and 0x04 hold 0x44, 0x05 to 0x07 hold 0x00, 0x08 holds 0x78, and the data line is released.
- R6: Writes to indices 0x00 to 0x02 are acknowledged and have no effect. Indices 0x00 and 0x02 read 0x00. Index 0x01 reads `{4'b0, sigDetect}`, with lane n at bit n.
- R7: Index bytes 0x09 to 0xFF are acknowledged. A write to such an index is discarded, and a read of it returns 0x00.
- R8: If the clock line stays low for `TimeoutCycles` system clocks during a transfer, the block abandons the transfer, releases the data line, and waits for a new START.
- R9: START is data falling while the clock is high. STOP is data rising while the clock is high. A STOP before the data byte is complete aborts the write with no register change. A repeated START restarts address matching while keeping the index.
- R10: `cfgRegs[8*(k-3) +: 8]` always equals writable register k, for k from 3 to 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rstN | input | 1 | Active-low synchronous reset |
| chipSel | input | 1 | High lets the block take part in bus transfers |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level as seen on the wire |
| sigDetect | input | 4 | Per-lane signal-detect status, lane n on bit n |
| sdaPullLow | output | 1 | Open-drain enable: high pulls the data line to 0 |
| cfgRegs | output | 48 | Writable registers 0x03..0x08, lowest index in the low byte |

## Verification
The bench aims at the places where a slave of this kind tends to lose sync. A repeated START arrives while the block is still expecting a data byte; a design that missed it would treat 0xAD as data and never return a read. A STOP in the middle of a byte must not commit a partial write, and a design that wrote early would corrupt index 0x04. An unmatched address or a low chip select must bring no acknowledge. A design that ignored either would pull the line and answer for another device. A host that stalls with the clock low must see the line released once the limit expires; without the watchdog the block would hold data low for good. Writes to read-only and unmapped indices must leave every control byte unchanged.

// File: rtl/smbPkg.sv
package smbPkg;

  localparam int RegCount   = 9;
  localparam int FirstRw    = 3;
  localparam int NumLanes   = 4;
  localparam int CfgBytes   = RegCount - FirstRw;
  localparam int CfgW       = CfgBytes * 8;
  localparam logic [7:0] StatusIdx = 8'h01;

  typedef enum logic [3:0] {
    sIdle, sDevAddr, sAckDev, sRegAddr, sAckReg,
    sWrData, sAckData, sRdData, sRdAck
  } busState_e;

  typedef struct packed {
    logic       wrEn;
    logic [7:0] addr;
    logic [7:0] wrData;
  } regStrobe_t;

  function automatic logic [CfgW-1:0] cfgDefault();
    logic [CfgW-1:0] v;
    v = '0;
    for (int k = 0; k < CfgBytes; k++) begin
      if (k + FirstRw == 3 || k + FirstRw == 4) v[k*8 +: 8] = 8'h44;
      else if (k + FirstRw == 8)                 v[k*8 +: 8] = 8'h78;
    end
    return v;
  endfunction

endpackage

// File: rtl/smbBusCtrl.sv
module smbBusCtrl
  import smbPkg::*;
#(
  parameter int         TimeoutCycles = 3_000_000,
  parameter logic [6:0] DevAddr       = 7'h56
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       chipSel,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [7:0] rdData,
  output regStrobe_t strobe,
  output logic       sdaPullLow
);

  localparam int ToW = $clog2(TimeoutCycles + 1);

  logic [2:0] sclQ, sdaQ;
  logic       sclS, sclP, sdaS, sdaP;
  logic       sclRise, sclFall, startC, stopC, toHit, rxState;
  busState_e  state;
  logic [3:0] bitCnt;
  logic [7:0] shReg, regPtr, wrDataQ;
  logic       isRead, wrEnQ;
  logic [ToW-1:0] toCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclQ <= '1;
      sdaQ <= '1;
    end else begin
      sclQ <= {sclQ[1:0], sclIn};
      sdaQ <= {sdaQ[1:0], sdaIn};
    end
  end

  assign sclS    = sclQ[1];
  assign sclP    = sclQ[2];
  assign sdaS    = sdaQ[1];
  assign sdaP    = sdaQ[2];
  assign sclRise = sclS & ~sclP;
  assign sclFall = ~sclS & sclP;
  assign startC  = sclS & sclP & sdaP & ~sdaS;
  assign stopC   = sclS & sclP & ~sdaP & sdaS;
  assign toHit   = (toCnt == ToW'(TimeoutCycles));
  assign rxState = (state == sDevAddr) || (state == sRegAddr) || (state == sWrData);

  always_ff @(posedge clk) begin
    if (!rstN || state == sIdle || sclS || toHit) toCnt <= '0;
    else                                         toCnt <= toCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= sIdle;
      bitCnt  <= '0;
      shReg   <= '0;
      regPtr  <= '0;
      wrDataQ <= '0;
      isRead  <= 1'b0;
      wrEnQ   <= 1'b0;
    end else begin
      wrEnQ <= 1'b0;
      if (!chipSel || stopC || toHit) begin
        state <= sIdle;
      end else if (startC) begin
        state  <= sDevAddr;
        bitCnt <= '0;
      end else begin
        if (sclRise && rxState) begin
          shReg  <= {shReg[6:0], sdaS};
          bitCnt <= bitCnt + 1'b1;
        end
        if (sclRise && state == sRdData) bitCnt <= bitCnt + 1'b1;
        if (sclFall) begin
          unique case (state)
            sDevAddr: if (bitCnt == 4'd8) begin
              if (shReg[7:1] == DevAddr) begin
                state  <= sAckDev;
                isRead <= shReg[0];
              end else begin
                state <= sIdle;
              end
            end
            sAckDev: begin
              bitCnt <= '0;
              if (isRead) begin
                shReg <= rdData;
                state <= sRdData;
              end else begin
                state <= sRegAddr;
              end
            end
            sRegAddr: if (bitCnt == 4'd8) begin
              regPtr <= shReg;
              state  <= sAckReg;
            end
            sAckReg: begin
              bitCnt <= '0;
              state  <= sWrData;
            end
            sWrData: if (bitCnt == 4'd8) begin
              wrEnQ   <= 1'b1;
              wrDataQ <= shReg;
              state   <= sAckData;
            end
            sRdData: begin
              if (bitCnt == 4'd8) state <= sRdAck;
              else                shReg <= {shReg[6:0], 1'b0};
            end
            default: state <= sIdle;
          endcase
        end
      end
    end
  end

  always_comb begin
    strobe.wrEn   = wrEnQ;
    strobe.addr   = regPtr;
    strobe.wrData = wrDataQ;
    sdaPullLow    = (state == sAckDev) || (state == sAckReg) || (state == sAckData)
                 || ((state == sRdData) && !shReg[7]);
  end

  a_r1_no_drive_deselected: assert property (@(posedge clk) disable iff (!rstN)
    !chipSel |=> !sdaPullLow);

  a_r2_ack_own_addr: assert property (@(posedge clk) disable iff (!rstN)
    (state == sAckDev) |-> (shReg[7:1] == DevAddr));

  a_r8_timeout_idle: assert property (@(posedge clk) disable iff (!rstN)
    toHit |=> (state == sIdle && !sdaPullLow));

  a_r9_start_restarts: assert property (@(posedge clk) disable iff (!rstN)
    (startC && chipSel && !toHit) |=> (state == sDevAddr));

endmodule

// File: rtl/smbRegFile.sv
module smbRegFile
  import smbPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  regStrobe_t          strobe,
  input  logic [NumLanes-1:0] sigDetect,
  output logic [7:0]          rdData,
  output logic [CfgW-1:0]     cfgRegs
);

  localparam logic [CfgW-1:0] CfgInit = cfgDefault();
  localparam logic [7:0]      FirstRwIdx = 8'(FirstRw);

  logic [CfgW-1:0] cfgQ;

  for (genvar g = 0; g < CfgBytes; g++) begin : gCfg
    always_ff @(posedge clk) begin
      if (!rstN)
        cfgQ[g*8 +: 8] <= CfgInit[g*8 +: 8];
      else if (strobe.wrEn && strobe.addr == 8'(g + FirstRw))
        cfgQ[g*8 +: 8] <= strobe.wrData;
    end
  end

  always_comb begin
    rdData = '0;
    if (strobe.addr == StatusIdx) rdData = {{(8-NumLanes){1'b0}}, sigDetect};
    for (int k = 0; k < CfgBytes; k++)
      if (strobe.addr == 8'(k + FirstRw)) rdData = cfgQ[k*8 +: 8];
  end

  assign cfgRegs = cfgQ;

  a_r6_ro_write_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && strobe.addr < FirstRwIdx) |=> $stable(cfgQ));

  a_r7_unmapped_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && strobe.addr >= 8'(RegCount)) |=> $stable(cfgQ));

  a_r3_write_lands: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && strobe.addr >= FirstRwIdx && strobe.addr < 8'(RegCount))
      |=> (rdData == $past(strobe.wrData)));

endmodule

// File: rtl/smbRegSlave.sv
module smbRegSlave
  import smbPkg::*;
#(
  parameter int         TimeoutCycles = 3_000_000,
  parameter logic [6:0] DevAddr       = 7'h56
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                chipSel,
  input  logic                sclIn,
  input  logic                sdaIn,
  input  logic [NumLanes-1:0] sigDetect,
  output logic                sdaPullLow,
  output logic [CfgW-1:0]     cfgRegs
);

  regStrobe_t strobe;
  logic [7:0] rdData;

  smbBusCtrl #(.TimeoutCycles(TimeoutCycles), .DevAddr(DevAddr)) uCtrl (
    .clk(clk), .rstN(rstN), .chipSel(chipSel), .sclIn(sclIn), .sdaIn(sdaIn),
    .rdData(rdData), .strobe(strobe), .sdaPullLow(sdaPullLow)
  );

  smbRegFile uRegs (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sigDetect(sigDetect),
    .rdData(rdData), .cfgRegs(cfgRegs)
  );

endmodule

// File: tb/sim_smbRegSlave.sv
module sim_smbRegSlave;
  localparam int ToCyc = 200;
  localparam int Q     = 10;
  // {req[3:0], isRead, index[7:0], data[7:0], expected[7:0]}
  localparam int NVec = 19;
  localparam logic [28:0] Vec [NVec] = '{
    {4'd5, 1'b1, 8'h04, 8'h00, 8'h44},   // R5 default
    {4'd5, 1'b1, 8'h08, 8'h00, 8'h78},   // R5 default
    {4'd5, 1'b1, 8'h06, 8'h00, 8'h00},   // R5 default
    {4'd3, 1'b0, 8'h03, 8'hA5, 8'h00},   // R3 write
    {4'd4, 1'b1, 8'h03, 8'h00, 8'hA5},   // R4 read back
    {4'd3, 1'b0, 8'h08, 8'h12, 8'h00},
    {4'd4, 1'b1, 8'h08, 8'h00, 8'h12},
    {4'd3, 1'b0, 8'h07, 8'h5C, 8'h00},
    {4'd4, 1'b1, 8'h07, 8'h00, 8'h5C},
    {4'd6, 1'b0, 8'h00, 8'hFF, 8'h00},   // R6 read-only
    {4'd6, 1'b1, 8'h00, 8'h00, 8'h00},
    {4'd6, 1'b0, 8'h01, 8'hFF, 8'h00},
    {4'd6, 1'b1, 8'h01, 8'h00, 8'h0A},   // sigDetect = 4'hA
    {4'd6, 1'b0, 8'h02, 8'h33, 8'h00},
    {4'd6, 1'b1, 8'h02, 8'h00, 8'h00},
    {4'd7, 1'b0, 8'h09, 8'h77, 8'h00},   // R7 unmapped
    {4'd7, 1'b1, 8'h09, 8'h00, 8'h00},
    {4'd7, 1'b1, 8'hFF, 8'h00, 8'h00},
    {4'd4, 1'b1, 8'h04, 8'h00, 8'h44}
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN, chipSel, sclH, sdaH;
  logic [3:0]  sd;
  logic        sdaPull;
  logic [47:0] cfg;
  logic        sdaLine;
  assign sdaLine = sdaH & ~sdaPull;

  smbRegSlave #(.TimeoutCycles(ToCyc)) u0 (
    .clk(clk), .rstN(rstN), .chipSel(chipSel), .sclIn(sclH), .sdaIn(sdaLine),
    .sigDetect(sd), .sdaPullLow(sdaPull), .cfgRegs(cfg)
  );

  int nChk = 0, nFail = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bitOut(input logic b, output logic seen);
    sdaH = b;   waitc(Q);
    sclH = 1'b1; waitc(Q);
    seen = sdaLine; waitc(Q);
    sclH = 1'b0; waitc(Q);
  endtask

  task automatic startCond();
    sdaH = 1'b1; waitc(Q);
    sclH = 1'b1; waitc(Q);
    sdaH = 1'b0; waitc(Q);
    sclH = 1'b0; waitc(Q);
  endtask

  task automatic stopCond();
    sdaH = 1'b0; waitc(Q);
    sclH = 1'b1; waitc(Q);
    sdaH = 1'b1; waitc(2*Q);
  endtask

  task automatic sendByte(input logic [7:0] v, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bitOut(v[i], s);
    bitOut(1'b1, s);
    ack = ~s;
  endtask

  task automatic recvByte(output logic [7:0] v);
    logic s;
    v = '0;
    for (int i = 0; i < 8; i++) begin
      bitOut(1'b1, s);
      v = {v[6:0], s};
    end
    bitOut(1'b1, s);
  endtask

  task automatic doWrite(input logic [7:0] idx, input logic [7:0] d);
    logic a;
    startCond();
    sendByte(8'hAC, a); chk(a, "R3 address ack", a, 1);
    sendByte(idx, a);   chk(a, "R3 index ack", a, 1);
    sendByte(d, a);     chk(a, "R3 data ack", a, 1);
    stopCond();
  endtask

  task automatic doRead(input logic [7:0] idx, output logic [7:0] d);
    logic a;
    startCond();
    sendByte(8'hAC, a); chk(a, "R4 address ack", a, 1);
    sendByte(idx, a);   chk(a, "R4 index ack", a, 1);
    startCond();
    sendByte(8'hAD, a); chk(a, "R4 read address ack", a, 1);
    recvByte(d);
    stopCond();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic a, s;
    rstN = 1'b0; chipSel = 1'b1; sclH = 1'b1; sdaH = 1'b1; sd = 4'hA;
    waitc(5);
    rstN = 1'b1;
    waitc(5);
    // R5 reset state at the ports
    chk(cfg == 48'h780000004444, "R5 cfg reset", cfg, 48'h780000004444);
    chk(sdaPull == 1'b0, "R5 line released", sdaPull, 0);

    for (int v = 0; v < NVec; v++) begin
      if (Vec[v][24]) begin
        doRead(Vec[v][23:16], d);
        chk(d == Vec[v][7:0], $sformatf("R%0d read idx %0h", Vec[v][28:25], Vec[v][23:16]), d, Vec[v][7:0]);
      end else begin
        doWrite(Vec[v][23:16], Vec[v][15:8]);
      end
    end
    // R10 cfgRegs layout, R6/R7 no side effects
    chk(cfg == 48'h125C000044A5, "R10 cfg layout", cfg, 48'h125C000044A5);

    // R6 status follows sigDetect
    sd = 4'h5;
    doRead(8'h01, d);
    chk(d == 8'h05, "R6 status lanes", d, 8'h05);

    // R2 foreign address: no ack, no write
    startCond();
    sendByte(8'h40, a); chk(!a, "R2 foreign addr nack", a, 0);
    sendByte(8'h04, a); chk(!a, "R2 later byte ignored", a, 0);
    sendByte(8'h99, a);
    stopCond();
    chk(cfg[15:8] == 8'h44, "R2 no write", cfg[15:8], 8'h44);

    // R1 chip select low
    chipSel = 1'b0;
    startCond();
    sendByte(8'hAC, a); chk(!a, "R1 deselected nack", a, 0);
    sendByte(8'h04, a);
    sendByte(8'h11, a);
    stopCond();
    chipSel = 1'b1;
    waitc(Q);
    chk(cfg[15:8] == 8'h44, "R1 no write when deselected", cfg[15:8], 8'h44);

    // R9 STOP after index byte, and STOP mid data byte
    startCond();
    sendByte(8'hAC, a);
    sendByte(8'h04, a);
    stopCond();
    startCond();
    sendByte(8'hAC, a);
    sendByte(8'h04, a);
    for (int i = 0; i < 4; i++) bitOut(1'b0, s);
    stopCond();
    chk(cfg[15:8] == 8'h44, "R9 aborted write", cfg[15:8], 8'h44);

    // R8 clock held low during acknowledge
    startCond();
    for (int i = 7; i >= 0; i--) bitOut(((8'hAC >> i) & 8'h01) != 0, s);
    sdaH = 1'b1;
    waitc(Q);
    chk(sdaPull == 1'b1, "R8 ack driven before stall", sdaPull, 1);
    waitc(ToCyc + 20);
    chk(sdaPull == 1'b0, "R8 released after timeout", sdaPull, 0);
    stopCond();
    doRead(8'h03, d);
    chk(d == 8'hA5, "R8 recovers after timeout", d, 8'hA5);

    // R3 final write then R10
    doWrite(8'h05, 8'h3C);
    chk(cfg[23:16] == 8'h3C, "R10 byte for index 5", cfg[23:16], 8'h3C);

    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

endmodule